// File: doc/BRIEF.md
# SD Command Issue Word Encoder

This block sits between a host-side command scheduler and the register file of an SD/MMC command engine. It takes one command descriptor at a time: opcode, 32-bit argument, response flags, data flag, direction, block count and block size. From it the block builds two words. The first is a packed send word that starts the engine. The second is the interrupt-enable mask that fits the command. The platform flush mode is a plain input pin, because it decides which completion interrupt the command waits on.

After a descriptor is accepted, the block drives a fixed issue sequence on a single-beat register write port. It writes the interrupt-enable mask, then writes all ones to the write-to-clear status register, then writes the argument. It then waits for the engine's busy flag to drop. If the flag stays high for `WAIT_LIMIT` cycles, the block gives up, pulses `soft_rst` for one cycle and carries on. Last, it writes the send word and pulses `issue_done` in the same cycle.

The descriptor port is valid/ready. `in_ready` is high only while the block is idle. A descriptor transfers on a clock edge where both `in_valid` and `in_ready` are high, and all descriptor fields are sampled at that edge. While a sequence runs, `in_ready` stays low and descriptor inputs have no effect, so a producer holds its descriptor until the block is idle again. The register write port has no back-pressure: every write completes in the cycle it is driven.

Top module: `sdcw_issuer`

## Requirements
- R1: The send word carries the opcode in bits [5:0]. Bit 6 is set exactly when the response-present flag is set.
- R2: A 136-bit response sets bit 7 (long response) and also bit 10 (skip response CRC), whatever the CRC flag says.
- R3: Bit 10 is set whenever the CRC flag is clear.
- R4: Bit 12 (stop data) is set only when the opcode is 12. Bit 11 is set exactly when the busy-response flag is set.
- R5: Bit 8 marks a data command. Bit 9 is set only for data writes. Bits [22:13] hold the block count minus one for data commands and are 0 without data.
- R6: Bits [31:23] hold the block size when a data command's size is below 512, and 0 when it is 512 or when there is no data.
- R7: The interrupt mask always has bits 1 to 6 set: response CRC error (1), response timeout (2), data CRC error (3), data timeout (4), RX FIFO full (5) and TX FIFO empty (6).
- R8: Exactly one completion bit is set in the mask. Bit 0 (response done) is set with no data. Bit 8 (DMA done) is set for data commands that are writes or that run in hardware flush mode. Bit 7 (transfer OK) is set for any other data command.
- R9: After acceptance, writes go out in this order on consecutive cycles: address 0 takes the mask, address 1 takes all ones, and address 2 takes the argument. Address 3 takes the send word, and only once `engine_busy` has been seen low.
- R10: If `engine_busy` stays high for `WAIT_LIMIT` cycles, `soft_rst` pulses for exactly one cycle, `WAIT_LIMIT`+1 cycles after the argument write. The send word is written in the next cycle.
- R11: `issue_done` is high exactly in the cycle of the send-word write. `send_word` and `irq_mask` show the words of the last accepted descriptor.
- R12: `in_ready` is low from acceptance until the sequence ends. Descriptor changes in that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Block idle, descriptor can be taken |
| cmd_opcode | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_present | input | 1 | Command expects a response |
| rsp_long | input | 1 | Response is 136 bits |
| rsp_crc | input | 1 | Response is CRC protected |
| rsp_busy | input | 1 | Response carries a busy phase |
| has_data | input | 1 | Command moves data |
| is_write | input | 1 | Data moves toward the card |
| blk_cnt | input | 11 | Number of blocks, at least 1 |
| blk_size | input | 10 | Bytes per block, 1 to 512 |
| hw_flush | input | 1 | Platform uses hardware flush for all data commands |
| engine_busy | input | 1 | Command engine still busy |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 2 | 0 irq enable, 1 status clear, 2 argument, 3 send |
| reg_wr_data | output | 32 | Register write data |
| soft_rst | output | 1 | One-cycle engine reset after wait timeout |
| issue_done | output | 1 | Send word written this cycle |
| send_word | output | 32 | Encoded send word of the current command |
| irq_mask | output | 9 | Interrupt-enable mask of the current command |

## Verification
The bench covers several edge cases of the encoding:
- A 512-byte block. A design that compares with less-or-equal would place 0 for 512 wrongly or leak a ninth-bit overflow into the field.
- A 136-bit response whose CRC flag is set. A design that copies the CRC flag alone would leave bit 10 clear.
- Opcode 12 against nearby opcodes. A loose decode would raise the stop bit on other commands.
- Reads in both flush modes. Wiring direction alone to the completion selection would pick transfer-OK when DMA-done is required.

On the sequencing side, the bench holds the busy flag high past the limit and expects exactly one reset pulse at a fixed distance from the argument write. It also releases the flag early and expects no reset. It changes the descriptor mid-sequence, which exposes a design that re-samples its inputs after acceptance.

// File: rtl/sdcw_pkg.sv
package sdcw_pkg;
  localparam int OPC_W  = 6;
  localparam int CNT_W  = 10;
  localparam int LEN_W  = 9;
  localparam int ARG_W  = 32;
  localparam int IRQ_W  = 9;
  localparam int FULL_BLK = 1 << LEN_W;

  // send word bit positions
  localparam int B_OPC   = 0;
  localparam int B_RESP  = B_OPC + OPC_W;
  localparam int B_LONG  = B_RESP + 1;
  localparam int B_DATA  = B_LONG + 1;
  localparam int B_WRITE = B_DATA + 1;
  localparam int B_NOCRC = B_WRITE + 1;
  localparam int B_BUSY  = B_NOCRC + 1;
  localparam int B_STOP  = B_BUSY + 1;
  localparam int B_CNT   = B_STOP + 1;
  localparam int B_LEN   = B_CNT + CNT_W;
  localparam int SEND_W  = B_LEN + LEN_W;

  // interrupt mask bit positions
  localparam int I_RESP_OK  = 0;
  localparam int I_RESP_CRC = 1;
  localparam int I_RESP_TMO = 2;
  localparam int I_DAT_CRC  = 3;
  localparam int I_DAT_TMO  = 4;
  localparam int I_RX_FULL  = 5;
  localparam int I_TX_EMPTY = 6;
  localparam int I_XFER_OK  = 7;
  localparam int I_DMA_DONE = 8;

  localparam logic [OPC_W-1:0] OPC_STOP = 6'd12;

  typedef enum logic [1:0] {
    RS_IRQEN = 2'd0,
    RS_CLEAR = 2'd1,
    RS_ARG   = 2'd2,
    RS_SEND  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic             rsp_present;
    logic             rsp_long;
    logic             rsp_crc;
    logic             rsp_busy;
    logic             has_data;
    logic             is_write;
    logic [CNT_W:0]   blk_cnt;
    logic [LEN_W:0]   blk_size;
  } cmd_desc_t;
endpackage

// File: rtl/sdcw_word_enc.sv
module sdcw_word_enc
  import sdcw_pkg::*;
(
  input  cmd_desc_t         desc,
  input  logic              hw_flush,
  output logic [SEND_W-1:0] send_word,
  output logic [IRQ_W-1:0]  irq_mask
);
  logic [CNT_W-1:0] cnt_field;
  logic [LEN_W-1:0] len_field;

  assign cnt_field = CNT_W'(desc.blk_cnt - 1'b1);
  assign len_field = (desc.blk_size < FULL_BLK) ? desc.blk_size[LEN_W-1:0] : '0;

  always_comb begin
    send_word = '0;
    send_word[B_OPC +: OPC_W] = desc.opcode;
    send_word[B_RESP]  = desc.rsp_present;
    send_word[B_LONG]  = desc.rsp_long;
    send_word[B_NOCRC] = desc.rsp_long | ~desc.rsp_crc;
    send_word[B_BUSY]  = desc.rsp_busy;
    send_word[B_STOP]  = (desc.opcode == OPC_STOP);
    if (desc.has_data) begin
      send_word[B_DATA]  = 1'b1;
      send_word[B_WRITE] = desc.is_write;
      send_word[B_CNT +: CNT_W] = cnt_field;
      send_word[B_LEN +: LEN_W] = len_field;
    end
  end

  always_comb begin
    irq_mask = '0;
    irq_mask[I_RESP_CRC] = 1'b1;
    irq_mask[I_RESP_TMO] = 1'b1;
    irq_mask[I_DAT_CRC]  = 1'b1;
    irq_mask[I_DAT_TMO]  = 1'b1;
    irq_mask[I_RX_FULL]  = 1'b1;
    irq_mask[I_TX_EMPTY] = 1'b1;
    if (!desc.has_data)
      irq_mask[I_RESP_OK] = 1'b1;
    else if (hw_flush || desc.is_write)
      irq_mask[I_DMA_DONE] = 1'b1;
    else
      irq_mask[I_XFER_OK] = 1'b1;
  end
endmodule

// File: rtl/sdcw_wait_timer.sv
module sdcw_wait_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/sdcw_issue_seq.sv
module sdcw_issue_seq
  import sdcw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     engine_busy,
  input  logic     expired,
  output logic     idle,
  output logic     run_wait,
  output logic     wr_en,
  output reg_sel_e wr_sel,
  output logic     soft_rst,
  output logic     done
);
  typedef enum logic [2:0] {
    S_IDLE, S_IRQ, S_CLR, S_ARG, S_WAIT, S_RST, S_SEND
  } seq_state_e;

  seq_state_e st, st_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (start) st_nx = S_IRQ;
      S_IRQ:  st_nx = S_CLR;
      S_CLR:  st_nx = S_ARG;
      S_ARG:  st_nx = S_WAIT;
      S_WAIT: begin
        if (!engine_busy)  st_nx = S_SEND;
        else if (expired)  st_nx = S_RST;
      end
      S_RST:  st_nx = S_SEND;
      S_SEND: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_sel = RS_IRQEN;
    unique case (st)
      S_IRQ:  begin wr_en = 1'b1; wr_sel = RS_IRQEN; end
      S_CLR:  begin wr_en = 1'b1; wr_sel = RS_CLEAR; end
      S_ARG:  begin wr_en = 1'b1; wr_sel = RS_ARG;   end
      S_SEND: begin wr_en = 1'b1; wr_sel = RS_SEND;  end
      default: ;
    endcase
  end

  assign idle     = (st == S_IDLE);
  assign run_wait = (st == S_WAIT);
  assign soft_rst = (st == S_RST);
  assign done     = (st == S_SEND);
endmodule

// File: rtl/sdcw_issuer.sv
module sdcw_issuer
  import sdcw_pkg::*;
#(
  parameter int WAIT_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  cmd_opcode,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              rsp_present,
  input  logic              rsp_long,
  input  logic              rsp_crc,
  input  logic              rsp_busy,
  input  logic              has_data,
  input  logic              is_write,
  input  logic [CNT_W:0]    blk_cnt,
  input  logic [LEN_W:0]    blk_size,
  input  logic              hw_flush,
  input  logic              engine_busy,
  output logic              reg_wr_en,
  output logic [1:0]        reg_wr_addr,
  output logic [31:0]       reg_wr_data,
  output logic              soft_rst,
  output logic              issue_done,
  output logic [SEND_W-1:0] send_word,
  output logic [IRQ_W-1:0]  irq_mask
);
  cmd_desc_t         desc;
  logic [SEND_W-1:0] send_nx;
  logic [IRQ_W-1:0]  irq_nx;
  logic [SEND_W-1:0] send_q;
  logic [IRQ_W-1:0]  irq_q;
  logic [ARG_W-1:0]  arg_q;
  logic              accept, idle, run_wait, expired, wr_en;
  reg_sel_e          wr_sel;

  assign desc = '{opcode: cmd_opcode, rsp_present: rsp_present,
                  rsp_long: rsp_long, rsp_crc: rsp_crc, rsp_busy: rsp_busy,
                  has_data: has_data, is_write: is_write,
                  blk_cnt: blk_cnt, blk_size: blk_size};

  sdcw_word_enc u_enc (
    .desc      (desc),
    .hw_flush  (hw_flush),
    .send_word (send_nx),
    .irq_mask  (irq_nx)
  );

  assign in_ready = idle;
  assign accept   = in_valid && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_q <= '0;
      irq_q  <= '0;
      arg_q  <= '0;
    end else if (accept) begin
      send_q <= send_nx;
      irq_q  <= irq_nx;
      arg_q  <= cmd_arg;
    end
  end

  sdcw_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_wait),
    .expired (expired)
  );

  sdcw_issue_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .engine_busy (engine_busy),
    .expired     (expired),
    .idle        (idle),
    .run_wait    (run_wait),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .soft_rst    (soft_rst),
    .done        (issue_done)
  );

  always_comb begin
    unique case (wr_sel)
      RS_IRQEN: reg_wr_data = 32'(irq_q);
      RS_CLEAR: reg_wr_data = '1;
      RS_ARG:   reg_wr_data = 32'(arg_q);
      default:  reg_wr_data = 32'(send_q);
    endcase
  end

  assign reg_wr_en   = wr_en;
  assign reg_wr_addr = wr_sel;
  assign send_word   = send_q;
  assign irq_mask    = irq_q;
endmodule

// File: rtl/sdcw_issuer_chk.sv
module sdcw_issuer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        engine_busy,
  input logic        reg_wr_en,
  input logic [1:0]  reg_wr_addr,
  input logic [31:0] reg_wr_data,
  input logic        soft_rst,
  input logic        issue_done
);
  logic send_wr;
  assign send_wr = reg_wr_en && (reg_wr_addr == 2'd3);

  // R11
  a_r11_done_with_send: assert property (@(posedge clk) disable iff (!rst_n)
    issue_done |-> send_wr);

  // R9
  a_r9_send_after_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
    send_wr |-> ($past(soft_rst) || !$past(engine_busy)));

  a_r9_clear_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == 2'd1) |-> (reg_wr_data == 32'hFFFF_FFFF));

  // R12
  a_r12_not_ready_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !in_ready);

  // R7
  a_r7_errors_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == 2'd0) |-> (reg_wr_data[6:1] == 6'h3F));

  // R8
  a_r8_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == 2'd0) |->
      ($countones({reg_wr_data[8], reg_wr_data[7], reg_wr_data[0]}) == 1));

  // R10
  a_r10_reset_single_then_send: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!soft_rst && send_wr));

  // R6
  a_r6_no_len_without_data: assert property (@(posedge clk) disable iff (!rst_n)
    (send_wr && !reg_wr_data[8]) |-> (reg_wr_data[31:13] == 19'd0));
endmodule

bind sdcw_issuer sdcw_issuer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .engine_busy (engine_busy),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .soft_rst    (soft_rst),
  .issue_done  (issue_done)
);

// File: tb/sdcw_issuer_tb.sv
module sdcw_issuer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  cmd_opcode = '0;
  logic [31:0] cmd_arg = '0;
  logic        rsp_present = 1'b0, rsp_long = 1'b0, rsp_crc = 1'b0, rsp_busy = 1'b0;
  logic        has_data = 1'b0, is_write = 1'b0;
  logic [10:0] blk_cnt = 11'd1;
  logic [9:0]  blk_size = 10'd512;
  logic        hw_flush = 1'b0;
  logic        engine_busy = 1'b0;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic        soft_rst, issue_done;
  logic [31:0] send_word;
  logic [8:0]  irq_mask;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [1:0]  lg_addr [0:7];
  logic [31:0] lg_data [0:7];
  int lg_n = 0;
  int arg_cyc = -1, rst_cyc = -1, done_cyc = -1, rst_count = 0;
  bit done_ok = 1'b0, ready_mid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcw_issuer #(.WAIT_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg), .rsp_present(rsp_present),
    .rsp_long(rsp_long), .rsp_crc(rsp_crc), .rsp_busy(rsp_busy),
    .has_data(has_data), .is_write(is_write), .blk_cnt(blk_cnt),
    .blk_size(blk_size), .hw_flush(hw_flush), .engine_busy(engine_busy),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .soft_rst(soft_rst), .issue_done(issue_done), .send_word(send_word),
    .irq_mask(irq_mask)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (reg_wr_en) begin
        if (lg_n < 8) begin
          lg_addr[lg_n] = reg_wr_addr;
          lg_data[lg_n] = reg_wr_data;
        end
        lg_n = lg_n + 1;
        if (reg_wr_addr == 2'd2) arg_cyc = cyc;
        if (in_ready) ready_mid = 1'b1;
      end
      if (soft_rst) begin rst_cyc = cyc; rst_count = rst_count + 1; end
      if (issue_done) begin
        done_cyc = cyc;
        done_ok = reg_wr_en && (reg_wr_addr == 2'd3);
      end
    end
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_send(input logic [5:0] op, input bit pres, lng, crc, bsy,
                                           dat, wr, input int cnt, input int size);
    logic [31:0] w;
    w = '0;
    w[5:0] = op;
    w[6] = pres;
    w[7] = lng;
    w[10] = lng | ~crc;
    w[11] = bsy;
    w[12] = (op == 6'd12);
    if (dat) begin
      w[8] = 1'b1;
      w[9] = wr;
      w[22:13] = 10'(cnt - 1);
      w[31:23] = (size < 512) ? 9'(size) : 9'd0;
    end
    return w;
  endfunction

  function automatic logic [8:0] exp_irq(input bit dat, wr, flush);
    logic [8:0] m;
    m = 9'b0_0111_1110;
    if (!dat) m[0] = 1'b1;
    else if (flush || wr) m[8] = 1'b1;
    else m[7] = 1'b1;
    return m;
  endfunction

  task automatic clear_log();
    lg_n = 0; arg_cyc = -1; rst_cyc = -1; done_cyc = -1; rst_count = 0;
    done_ok = 1'b0; ready_mid = 1'b0;
  endtask

  task automatic drive(input logic [5:0] op, input logic [31:0] arg, input bit pres, lng, crc, bsy,
                       dat, wr, input int cnt, input int size, input bit flush);
    cmd_opcode = op; cmd_arg = arg; rsp_present = pres; rsp_long = lng; rsp_crc = crc;
    rsp_busy = bsy; has_data = dat; is_write = wr; blk_cnt = 11'(cnt);
    blk_size = 10'(size); hw_flush = flush;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && done_cyc < 0; i++) @(negedge clk);
  endtask

  // start one issue, check writes, words and done pulse
  task automatic issue(input string tag, input logic [5:0] op, input logic [31:0] arg,
                       input bit pres, lng, crc, bsy, dat, wr, input int cnt, input int size,
                       input bit flush);
    logic [31:0] es;
    logic [8:0]  ei;
    es = exp_send(op, pres, lng, crc, bsy, dat, wr, cnt, size);
    ei = exp_irq(dat, wr, flush);
    @(negedge clk);
    clear_log();
    drive(op, arg, pres, lng, crc, bsy, dat, wr, cnt, size, flush);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_done();
    @(negedge clk);
    chk(lg_n == 4 && lg_addr[0] == 2'd0 && lg_addr[1] == 2'd1 && lg_addr[2] == 2'd2 &&
        lg_addr[3] == 2'd3, {"R9 order ", tag}, 32'(lg_n), 32'd4);
    chk(lg_data[1] == 32'hFFFF_FFFF && lg_data[2] == arg, {"R9 clear/arg ", tag}, lg_data[2], arg);
    chk(lg_data[0] == 32'(ei), {"R7 R8 irq mask ", tag}, lg_data[0], 32'(ei));
    chk(lg_data[3] == es, {"R1-6 send word ", tag}, lg_data[3], es);
    chk(done_ok && send_word == es && irq_mask == ei, {"R11 done/outputs ", tag}, send_word, es);
  endtask

  task automatic t_reset();
    chk(in_ready && !reg_wr_en && !soft_rst && !issue_done, "R12 reset idle",
        {28'd0, in_ready, reg_wr_en, soft_rst, issue_done}, 32'h8);
    chk(send_word == 32'd0 && irq_mask == 9'd0, "R11 reset words", send_word, 32'd0);
  endtask

  task automatic t_no_resp();   issue("R1 no response",    6'd0,  32'h0,        0,0,0,0, 0,0, 1,   512, 0); endtask
  task automatic t_short_resp(); issue("R1 R3 short crc",   6'd13, 32'hA5A5_0001, 1,0,1,0, 0,0, 1,   512, 0); endtask
  task automatic t_long_resp();  issue("R2 long with crc",  6'd2,  32'h0,        1,1,1,0, 0,0, 1,   512, 0); endtask
  task automatic t_no_crc();     issue("R3 no crc",         6'd41, 32'h40FF_8000, 1,0,0,0, 0,0, 1,   512, 0); endtask
  task automatic t_stop();       issue("R4 stop busy",      6'd12, 32'h0,        1,0,1,1, 0,0, 1,   512, 0); endtask
  task automatic t_near_stop();  issue("R4 opcode 44",      6'd44, 32'h1,        1,0,1,1, 0,0, 1,   512, 0); endtask
  task automatic t_write_full(); issue("R5 R6 write 512",   6'd25, 32'h0000_1000, 1,0,1,0, 1,1, 1024,512, 0); endtask
  task automatic t_read_sw();    issue("R5 R6 R8 read sw",  6'd18, 32'h0000_0200, 1,0,1,0, 1,0, 8,   64,  0); endtask
  task automatic t_read_hw();    issue("R8 read hw flush",  6'd17, 32'h0000_0003, 1,0,1,0, 1,0, 1,   511, 1); endtask
  task automatic t_small_blk();  issue("R6 size 1",         6'd53, 32'h7,        1,0,1,0, 1,1, 2,   1,   0); endtask

  task automatic t_timeout();
    engine_busy = 1'b1;
    issue("R10 timeout", 6'd7, 32'h1234_0000, 1,0,1,1, 0,0, 1, 512, 0);
    chk(rst_count == 1, "R10 one reset pulse", 32'(rst_count), 32'd1);
    chk(rst_cyc - arg_cyc == LIMIT + 1, "R10 reset distance", 32'(rst_cyc - arg_cyc), 32'(LIMIT + 1));
    chk(done_cyc == rst_cyc + 1, "R10 send after reset", 32'(done_cyc - rst_cyc), 32'd1);
    engine_busy = 1'b0;
  endtask

  task automatic t_late_busy();
    engine_busy = 1'b1;
    fork
      issue("R9 busy released", 6'd6, 32'h0300_0001, 1,0,1,1, 0,0, 1, 512, 0);
      begin repeat (8) @(negedge clk); engine_busy = 1'b0; end
    join
    chk(rst_count == 0, "R9 no reset when busy drops", 32'(rst_count), 32'd0);
    chk(done_cyc - arg_cyc >= 4, "R9 send waits for busy", 32'(done_cyc - arg_cyc), 32'd4);
  endtask

  task automatic t_backpressure();
    logic [31:0] es;
    es = exp_send(6'd24, 1,0,1,0, 1,1, 3, 512);
    @(negedge clk);
    clear_log();
    drive(6'd24, 32'hCAFE_0000, 1,0,1,0, 1,1, 3, 512, 0);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    drive(6'd12, 32'h0BAD_0BAD, 0,1,0,1, 0,0, 7, 9, 1);
    @(negedge clk);
    chk(!in_ready, "R12 ready low mid sequence", 32'(in_ready), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk(lg_n == 4 && lg_data[3] == es, "R12 changes ignored", lg_data[3], es);
    chk(lg_data[2] == 32'hCAFE_0000 && !ready_mid, "R12 argument held", lg_data[2], 32'hCAFE_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_no_resp();
    t_short_resp();
    t_long_resp();
    t_no_crc();
    t_stop();
    t_near_stop();
    t_write_full();
    t_read_sw();
    t_read_hw();
    t_small_blk();
    t_timeout();
    t_late_busy();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule